// File: doc/BRIEF.md
# Two-Cycle Radix-2 Decimation-in-Frequency Butterfly

This block performs one radix-2 decimation-in-frequency butterfly on complex operands held as 12-bit signed fractions in Q1.11, with the real and imaginary parts each 12 bits. From operands A and B and twiddle W it forms a sum result, A' = (A + B) / 2, and a rotated difference, B' = ((A − B) · W) / 2. Halving both results at every stage keeps the fixed-point data in range. Over a chain of stages the halving builds up, so eight stages of a 256-point transform scale the output by 1/256.

A new operand set can be taken every second clock. Only two real signed multipliers exist. The four partial products of the complex multiply are split across the two cycles: the real part of the product is formed in the first cycle and the imaginary part in the second. A' and B' leave on a single result port, one complex value per cycle. This pace matches a dual-port data memory that does one read and one write per cycle. A select bit tells which of the two results is on the port.

Top module: `dif_bfly2`

## Requirements
- R1: While reset is high, and in the cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: An operand set is taken only when in_valid and in_ready are both 1 at a clock edge. in_ready is 0 in the cycle that follows an accept and 1 again in the cycle after that. If in_valid is 1 while in_ready is 0, nothing is accepted and the result stream is unaffected.
- R3: A' appears two cycles after the accept edge, with out_valid = 1 and out_sel = 0. Each part equals floor((x_A + x_B + 1) / 2), where x is the part's integer value.
- R4: The real part of B' is sat(floor((Dr·Wr − Di·Wi + 2048) / 4096)), where D = A − B is formed at 13 bits.
- R5: The imaginary part of B' is sat(floor((Dr·Wi + Di·Wr + 2048) / 4096)).
- R6: B' is presented in the cycle directly after A', with out_valid = 1 and out_sel = 1.
- R7: sat() clamps the value to the 12-bit range, from −2048 (0x800) to 2047 (0x7FF).
- R8: out_valid is 1 only in the two result cycles of each accepted operand set. The port emits exactly two results for each accept.
- R9: A twiddle part of 0x800 (−1.0) is handled without error. Operands accepted back to back, one set every second cycle, produce results without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set this cycle |
| a_re | input | 12 | Operand A, real part (Q1.11) |
| a_im | input | 12 | Operand A, imaginary part |
| b_re | input | 12 | Operand B, real part |
| b_im | input | 12 | Operand B, imaginary part |
| w_re | input | 12 | Twiddle, real part |
| w_im | input | 12 | Twiddle, imaginary part |
| out_valid | output | 1 | A result is on the port |
| out_sel | output | 1 | 0 = A', 1 = B' |
| out_re | output | 12 | Result, real part |
| out_im | output | 12 | Result, imaginary part |

## Verification
A fault in the phase register shows up within one or two cycles of an accept. It appears as a wrong in_ready, a result cycle with no valid strobe, or A' and B' in the wrong order. A fault in the operand muxing between the two cycles pairs the wrong partial products. That shows as a wrong imaginary or real part of B' three cycles after the accept, while A' still comes out correct. A corrupted stored real part of B', or operand registers overwritten during the not-ready cycle, show up in the B' that follows.

// File: rtl/dif_bfly2.sv
module dif_bfly2 #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a_re,
  input  logic [W-1:0] a_im,
  input  logic [W-1:0] b_re,
  input  logic [W-1:0] b_im,
  input  logic [W-1:0] w_re,
  input  logic [W-1:0] w_im,
  output logic         out_valid,
  output logic         out_sel,
  output logic [W-1:0] out_re,
  output logic [W-1:0] out_im
);
  localparam int DW = W + 1;
  localparam int PW = DW + W;
  localparam int AW = PW + 2;
  localparam int FR = W - 1;

  logic                 phase, pend;
  logic signed [W-1:0]  ah_re, ah_im, wq_re, wq_im, bre_q;
  logic signed [DW-1:0] d_re, d_im;

  logic signed [DW-1:0] s_re_c, s_im_c, d_re_c, d_im_c;
  logic signed [DW-1:0] m0a, m1a;
  logic signed [W-1:0]  m0b, m1b;
  logic signed [PW-1:0] m0, m1;
  logic signed [AW-1:0] sum, rnd, sh;
  logic signed [W-1:0]  prod;

  wire accept = in_valid && in_ready;
  assign in_ready = !phase;

  assign s_re_c = {a_re[W-1], a_re} + {b_re[W-1], b_re} + DW'(1);
  assign s_im_c = {a_im[W-1], a_im} + {b_im[W-1], b_im} + DW'(1);
  assign d_re_c = {a_re[W-1], a_re} - {b_re[W-1], b_re};
  assign d_im_c = {a_im[W-1], a_im} - {b_im[W-1], b_im};

  assign m0a = phase ? d_re : d_re;
  assign m1a = phase ? d_im : d_im;
  assign m0b = phase ? wq_re : wq_im;
  assign m1b = phase ? wq_im : wq_re;
  assign m0  = m0a * m0b;
  assign m1  = m1a * m1b;

  always_comb begin
    if (phase) sum = AW'(m0) - AW'(m1);
    else       sum = AW'(m0) + AW'(m1);
    rnd = sum + (AW'(1) <<< FR);
    sh  = rnd >>> (FR + 1);
    if (sh > AW'((1 << (W-1)) - 1))
      prod = W'((1 << (W-1)) - 1);
    else if (sh < -AW'(1 << (W-1)))
      prod = W'(1 << (W-1));
    else
      prod = sh[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_sel   <= 1'b0;
    end else begin
      phase     <= accept;
      pend      <= phase;
      out_valid <= phase | pend;
      out_sel   <= pend;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ah_re <= s_re_c[DW-1:1];
      ah_im <= s_im_c[DW-1:1];
      d_re  <= d_re_c;
      d_im  <= d_im_c;
      wq_re <= w_re;
      wq_im <= w_im;
    end
    if (phase) begin
      out_re <= ah_re;
      out_im <= ah_im;
      bre_q  <= prod;
    end else if (pend) begin
      out_re <= bre_q;
      out_im <= prod;
    end
  end
endmodule

module dif_bfly2_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_sel
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_back_r2: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  p_first_result_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 (out_valid && !out_sel));

  p_second_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sel) |=> (out_valid && out_sel));

  p_no_lone_second_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sel) |-> $past(out_valid && !out_sel));
endmodule

bind dif_bfly2 dif_bfly2_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sel(out_sel)
);

// File: tb/dif_bfly2_tb.sv
`timescale 1ns/1ps
module dif_bfly2_tb;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [11:0] a_re = 0, a_im = 0, b_re = 0, b_im = 0, w_re = 0, w_im = 0;
  logic in_ready, out_valid, out_sel;
  logic [11:0] out_re, out_im;

  dif_bfly2 u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .out_valid(out_valid), .out_sel(out_sel), .out_re(out_re), .out_im(out_im));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, wr = 0, rd = 0;
  int exp_re [0:1023];
  int exp_im [0:1023];
  int exp_cyc[0:1023];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sat12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int half_up(input int s);
    return (s + 1) >>> 1;
  endfunction

  function automatic int prod_rnd(input int p);
    return sat12((p + 2048) >>> 12);
  endfunction

  task automatic send(input int ar, ai, br, bi, xr, xi, input bit junk);
    int dr, di;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a_re = 12'(ar); a_im = 12'(ai); b_re = 12'(br); b_im = 12'(bi);
    w_re = 12'(xr); w_im = 12'(xi); in_valid = 1;
    dr = ar - br; di = ai - bi;
    exp_re[wr] = half_up(ar + br); exp_im[wr] = half_up(ai + bi); exp_cyc[wr] = cyc + 2;
    exp_re[wr+1] = prod_rnd(dr*xr - di*xi);
    exp_im[wr+1] = prod_rnd(dr*xi + di*xr);
    exp_cyc[wr+1] = cyc + 3;
    wr += 2;
    @(negedge clk);
    if (junk) begin
      a_re = 12'($urandom); a_im = 12'($urandom); b_re = 12'($urandom);
      b_im = 12'($urandom); w_re = 12'($urandom); w_im = 12'($urandom);
      chk(in_ready == 0, "R2 ready low after accept", in_ready, 0);
      @(posedge clk); #1 in_valid = 0;
    end else in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd >= wr) chk(0, "R8 unexpected out_valid", rd, wr);
      else begin
        chk(out_sel == rd[0], rd[0] ? "R6 out_sel B'" : "R3 out_sel A'", out_sel, rd[0]);
        chk(cyc == exp_cyc[rd], rd[0] ? "R6 B' timing" : "R3 A' timing", cyc, exp_cyc[rd]);
        chk($signed(out_re) == exp_re[rd], rd[0] ? "R4 R7 B' real" : "R3 A' real",
            $signed(out_re), exp_re[rd]);
        chk($signed(out_im) == exp_im[rd], rd[0] ? "R5 R7 B' imag" : "R3 A' imag",
            $signed(out_im), exp_im[rd]);
        rd++;
      end
    end
  end

  task automatic rnd_cplx(output int re, output int im);
    do begin
      re = int'($urandom_range(4094)) - 2047;
      im = int'($urandom_range(4094)) - 2047;
    end while (re*re + im*im >= 2048*2048);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int ar, ai, br, bi, xr, xi;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    send(1024, 0, 0, 0, -2048, 0, 0);       // R9 twiddle -1.0
    send(2047, -2048, -2048, 2047, -2048, -2048, 0); // R7 negative saturation
    send(2047, 2047, -2048, -2048, 2047, -2048, 1);  // R7 positive saturation, R2 junk
    send(-2048, -2048, -2048, -2048, 2047, 2047, 0);
    send(1, 1, 0, 0, 2047, 0, 0);            // R3 rounding of odd sum
    send(-1, -1, 0, 0, 0, -2048, 1);
    send(700, -300, -900, 1200, 0, 2047, 0);

    for (int i = 0; i < 300; i++) begin
      rnd_cplx(ar, ai); rnd_cplx(br, bi); rnd_cplx(xr, xi);
      send(ar, ai, br, bi, xr, xi, bit'(i % 3 == 0));
      if (i % 17 == 0) repeat (int'($urandom_range(3))) @(negedge clk);
    end

    repeat (8) @(negedge clk);
    chk(rd == wr, "R8 result count", rd, wr);
    chk(out_valid == 0, "R8 idle after drain", out_valid, 0);
    chk(in_ready == 1, "R2 ready when idle", in_ready, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule